// File: doc/BRIEF.md
# Tag and Force Breakpoint Unit

This block converts comparator match signals into breakpoint requests for a CPU. Each comparator is set to one of two kinds by a per-comparator select.

- **Force kind.** A match arms a pending request. The request waits until the current instruction completes. It then asks the CPU to enter active background mode instead of continuing with the next instruction.
- **Tag kind.** A match that coincides with an opcode fetch attaches a flag to that opcode. The flag moves through a small instruction queue together with the opcode. It has an effect only if that opcode is actually executed. In that case the unit raises a substitute flag, so the CPU runs a background-entry opcode in place of the tagged one, and a background request follows.

The CPU core signals a queue flush when a jump, branch, call or interrupt discards prefetched opcodes. A flush drops their flags, so breakpoints on opcodes that were fetched but never executed never fire.

The unit also gives the trigger logic a qualified match per comparator:
- a force-kind comparator reports its match at once;
- a tag-kind comparator reports only when its tagged opcode executes.

A single request line is held until the CPU acknowledges entry into background mode. Further breakpoint events that arrive while a request is pending or active merge into that one request.

Top module: `bkpt_unit`

## Requirements
- R1: After reset is released, and before any stimulus, `bgnd_req_o` is 0, `subst_o` is 0, `trig_o` is all zeros, and the instruction queue is empty.
- R2: A tag-kind match (`match_i[k]=1` with `tag_sel_i[k]=1`) in a cycle with `fetch_i=1` attaches bit k to the fetched opcode. In that cycle it leaves `trig_o[k]` at 0 and raises no background request.
- R3: In a cycle with `exec_i=1`, `flush_i=0` and a queue head carrying a non-zero tag, `subst_o` is 1 in that same cycle and `trig_o` includes the head's tag bits. Otherwise `subst_o` is 0.
- R4: A cycle with `subst_o=1` makes `bgnd_req_o` 1 in the next cycle.
- R5: A flush empties the queue. An `exec_i` or `fetch_i` in the same cycle as the flush has no effect, so `subst_o` is 0 in the flush cycle and in the cycle after it.
- R6: A force-kind match (`tag_sel_i[k]=0`) drives `trig_o[k]` in the same cycle and arms a pending request. `bgnd_req_o` rises in the cycle after the first `insn_done_i` that follows the match cycle.
- R7: A force match that arrives while a request is pending merges into it. A force match that arrives while `bgnd_req_o` is 1 is dropped. In neither case does it change when or how long the request is asserted.
- R8: `bgnd_req_o` stays 1 until a cycle with `bgnd_ack_i=1`, and is 0 in the following cycle unless `subst_o` was 1 in that acknowledge cycle.
- R9: The queue holds two opcodes in fetch order. A fetch into a full queue is ignored unless an execute happens in the same cycle. An execute on an empty queue has no effect. A tag-kind match without `fetch_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| match_i | input | N_CMP | Comparator match signals |
| tag_sel_i | input | N_CMP | Per-comparator kind: 1 = tag, 0 = force |
| fetch_i | input | 1 | An opcode enters the instruction queue |
| exec_i | input | 1 | The queue head opcode begins execution |
| flush_i | input | 1 | Discard all prefetched queue entries |
| insn_done_i | input | 1 | The current instruction completes |
| bgnd_ack_i | input | 1 | CPU acknowledges entry into background mode |
| bgnd_req_o | output | 1 | Background-mode request to the CPU |
| subst_o | output | 1 | Replace the executing opcode with a background-entry opcode |
| trig_o | output | N_CMP | Qualified match per comparator for the trigger logic |

## Verification
A wrong tag bit in a queue entry stays hidden until that entry reaches the head and executes. At that point `subst_o` and the tag-kind `trig_o` bits are wrong in the execute cycle, and `bgnd_req_o` is wrong one cycle later. This can be several cycles after the fetch, or never if a flush intervenes. A wrong pending-force state shows up only at the next `insn_done_i`, as a missing or spurious rise of `bgnd_req_o`.

The bench therefore runs long pseudo-random sequences over all input combinations with a two-entry queue and two comparators. It compares every output in every cycle against an arithmetic model of the queue and the request state.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  typedef enum logic [1:0] {
    FC_IDLE = 2'd0,
    FC_WAIT = 2'd1,
    FC_REQ  = 2'd2
  } force_st_e;
endpackage

// File: rtl/bkpt_tag_queue.sv
module bkpt_tag_queue #(
  parameter int DEPTH = 2,
  parameter int TW    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [TW-1:0] tag_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic          head_valid_o,
  output logic [TW-1:0] head_tag_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]          vld_q, vld_d;
  logic [DEPTH-1:0][TW-1:0]  tag_q, tag_d;
  logic [CW-1:0]             cnt, wr_idx;
  logic                      pop_eff, push_eff, full;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < DEPTH; i++) cnt = cnt + CW'(vld_q[i]);
  end

  assign full     = vld_q[DEPTH-1];
  assign pop_eff  = pop_i & vld_q[0] & ~flush_i;
  assign push_eff = push_i & ~flush_i & (~full | pop_eff);
  assign wr_idx   = cnt - CW'(pop_eff);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic          src_v;
    logic [TW-1:0] src_t;
    if (i < DEPTH - 1) begin : g_mid
      assign src_v = pop_eff ? vld_q[i+1] : vld_q[i];
      assign src_t = pop_eff ? tag_q[i+1] : tag_q[i];
    end else begin : g_last
      assign src_v = pop_eff ? 1'b0 : vld_q[i];
      assign src_t = pop_eff ? '0   : tag_q[i];
    end
    always_comb begin
      vld_d[i] = src_v;
      tag_d[i] = src_t;
      if (flush_i) begin
        vld_d[i] = 1'b0;
        tag_d[i] = '0;
      end else if (push_eff && wr_idx == CW'(i)) begin
        vld_d[i] = 1'b1;
        tag_d[i] = tag_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      tag_q <= '0;
    end else begin
      vld_q <= vld_d;
      tag_q <= tag_d;
    end
  end

  assign head_valid_o = vld_q[0];
  assign head_tag_o   = tag_q[0];
endmodule

// File: rtl/bkpt_trig_qual.sv
module bkpt_trig_qual #(
  parameter int N_CMP = 2
) (
  input  logic [N_CMP-1:0] match_i,
  input  logic [N_CMP-1:0] tag_sel_i,
  input  logic             exec_i,
  input  logic             flush_i,
  input  logic             head_valid_i,
  input  logic [N_CMP-1:0] head_tag_i,
  output logic [N_CMP-1:0] tag_in_o,
  output logic             force_hit_o,
  output logic             fire_o,
  output logic [N_CMP-1:0] trig_o
);
  logic [N_CMP-1:0] force_m;

  assign force_m     = match_i & ~tag_sel_i;
  assign tag_in_o    = match_i & tag_sel_i;
  assign force_hit_o = |force_m;
  assign fire_o      = exec_i & ~flush_i & head_valid_i & (|head_tag_i);
  assign trig_o      = force_m | (fire_o ? head_tag_i : '0);
endmodule

// File: rtl/bkpt_force_ctl.sv
module bkpt_force_ctl
  import bkpt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_hit_i,
  input  logic tag_fire_i,
  input  logic insn_done_i,
  input  logic ack_i,
  output logic req_o
);
  force_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FC_IDLE: if (tag_fire_i) st_d = FC_REQ;
               else if (force_hit_i) st_d = FC_WAIT;
      FC_WAIT: if (tag_fire_i || insn_done_i) st_d = FC_REQ;
      FC_REQ:  if (ack_i && !tag_fire_i) st_d = FC_IDLE;
      default: st_d = FC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= FC_IDLE;
    else         st_q <= st_d;
  end

  assign req_o = (st_q == FC_REQ);
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit #(
  parameter int N_CMP = 2,
  parameter int DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CMP-1:0] match_i,
  input  logic [N_CMP-1:0] tag_sel_i,
  input  logic             fetch_i,
  input  logic             exec_i,
  input  logic             flush_i,
  input  logic             insn_done_i,
  input  logic             bgnd_ack_i,
  output logic             bgnd_req_o,
  output logic             subst_o,
  output logic [N_CMP-1:0] trig_o
);
  logic             head_valid;
  logic [N_CMP-1:0] head_tag, tag_in;
  logic             force_hit, fire;

  bkpt_trig_qual #(.N_CMP(N_CMP)) qual_i (
    .match_i      (match_i),
    .tag_sel_i    (tag_sel_i),
    .exec_i       (exec_i),
    .flush_i      (flush_i),
    .head_valid_i (head_valid),
    .head_tag_i   (head_tag),
    .tag_in_o     (tag_in),
    .force_hit_o  (force_hit),
    .fire_o       (fire),
    .trig_o       (trig_o)
  );

  bkpt_tag_queue #(.DEPTH(DEPTH), .TW(N_CMP)) queue_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (fetch_i),
    .tag_i        (tag_in),
    .pop_i        (exec_i),
    .flush_i      (flush_i),
    .head_valid_o (head_valid),
    .head_tag_o   (head_tag)
  );

  bkpt_force_ctl ctl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .force_hit_i (force_hit),
    .tag_fire_i  (fire),
    .insn_done_i (insn_done_i),
    .ack_i       (bgnd_ack_i),
    .req_o       (bgnd_req_o)
  );

  assign subst_o = fire;
endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk #(
  parameter int N_CMP = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             exec_i,
  input logic             flush_i,
  input logic             insn_done_i,
  input logic             bgnd_ack_i,
  input logic             bgnd_req_o,
  input logic             subst_o
);
  AST_SUBST_NEEDS_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    subst_o |-> (exec_i && !flush_i)); // R3
  AST_REQ_AFTER_SUBST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    subst_o |=> bgnd_req_o); // R4
  AST_NO_SUBST_AFTER_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !subst_o); // R5
  AST_REQ_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bgnd_req_o) |-> $past(subst_o || insn_done_i)); // R6
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bgnd_req_o && !bgnd_ack_i) |=> bgnd_req_o); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bgnd_req_o && bgnd_ack_i && !subst_o) |=> !bgnd_req_o); // R8
endmodule

bind bkpt_unit bkpt_unit_chk #(.N_CMP(N_CMP)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .exec_i      (exec_i),
  .flush_i     (flush_i),
  .insn_done_i (insn_done_i),
  .bgnd_ack_i  (bgnd_ack_i),
  .bgnd_req_o  (bgnd_req_o),
  .subst_o     (subst_o)
);

// File: tb/bkpt_unit_tb_top.sv
module bkpt_unit_tb_top;
  localparam int N = 2;
  localparam int D = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] match, tsel;
  logic         fetch, exec, flush, done, ack;
  logic         req, subst;
  logic [N-1:0] trig;

  int checks = 0;
  int errors = 0;

  int           m_cnt;
  logic [N-1:0] m_q [D];
  logic         m_req, m_pend;

  always #4 clk = ~clk;

  bkpt_unit #(.N_CMP(N), .DEPTH(D)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .match_i(match), .tag_sel_i(tsel),
    .fetch_i(fetch), .exec_i(exec), .flush_i(flush), .insn_done_i(done),
    .bgnd_ack_i(ack), .bgnd_req_o(req), .subst_o(subst), .trig_o(trig)
  );

  task automatic chk(input string lab, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b t=%0t", lab, act, exp, $time);
    end
  endtask

  task automatic step(input logic [N-1:0] m, input logic [N-1:0] s, input logic f,
                      input logic e, input logic fl, input logic d, input logic a,
                      input string lab);
    logic         x_fire, nreq, npend, fh;
    logic [N-1:0] x_trig;
    @(negedge clk);
    match = m; tsel = s; fetch = f; exec = e; flush = fl; done = d; ack = a;
    #1;
    x_fire = e && !fl && m_cnt > 0 && (|m_q[0]);
    x_trig = (m & ~s) | (x_fire ? m_q[0] : '0);
    fh     = |(m & ~s);
    chk({lab, " R3 subst"}, N'(subst), N'(x_fire));
    chk({lab, " R2 R6 trig"}, trig, x_trig);
    chk({lab, " R4 R7 R8 bgnd_req"}, N'(req), N'(m_req));
    if (m_req) begin
      nreq = !a || x_fire; npend = 1'b0;
    end else if (m_pend) begin
      nreq = x_fire || d; npend = !nreq;
    end else begin
      nreq = x_fire; npend = !x_fire && fh;
    end
    @(posedge clk);
    m_req = nreq; m_pend = npend;
    if (fl) m_cnt = 0;
    else begin
      if (e && m_cnt > 0) begin
        for (int i = 0; i < D - 1; i++) m_q[i] = m_q[i+1];
        m_cnt--;
      end
      if (f && m_cnt < D) begin
        m_q[m_cnt] = m & s;
        m_cnt++;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    match = '0; tsel = '0; fetch = 0; exec = 0; flush = 0; done = 0; ack = 0;
    m_cnt = 0; m_req = 0; m_pend = 0;
    for (int i = 0; i < D; i++) m_q[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 bgnd_req", N'(req), '0);
    chk("R1 subst", N'(subst), '0);
    chk("R1 trig", trig, '0);
    step('0, '0, 0, 1, 0, 0, 0, "R1 R9 exec on empty");
    // tagged fetch, plain fetch, execute both
    step(2'b01, 2'b01, 1, 0, 0, 0, 0, "R2 tag attach");
    step(2'b00, 2'b11, 1, 0, 0, 0, 0, "R9 plain fetch");
    step(2'b01, 2'b01, 1, 0, 0, 0, 0, "R9 fetch when full");
    step('0, '0, 0, 1, 0, 0, 0, "R3 exec tagged head");
    step('0, '0, 0, 1, 0, 0, 0, "R4 R9 exec plain");
    step('0, '0, 0, 1, 0, 0, 1, "R8 ack");
    step('0, '0, 0, 0, 0, 0, 0, "R8 after ack");
    // tag-kind match without a fetch
    step(2'b10, 2'b10, 0, 0, 0, 0, 0, "R9 tag match no fetch");
    step('0, '0, 1, 0, 0, 0, 0, "R9 plain fetch");
    step('0, '0, 0, 1, 0, 0, 0, "R9 exec untagged");
    // flush discards tags
    step(2'b11, 2'b11, 1, 0, 0, 0, 0, "R5 tagged fetch");
    step(2'b11, 2'b11, 1, 1, 1, 0, 0, "R5 flush with exec");
    step('0, '0, 0, 1, 0, 0, 0, "R5 exec after flush");
    // force request, merge, completion
    step(2'b10, 2'b00, 0, 0, 0, 1, 0, "R6 force match");
    step(2'b01, 2'b00, 0, 0, 0, 0, 0, "R7 merge force");
    step('0, '0, 0, 0, 0, 1, 0, "R6 insn done");
    step(2'b11, 2'b00, 0, 0, 0, 1, 0, "R7 force while req");
    step('0, '0, 0, 0, 0, 0, 1, "R8 ack force");
    step('0, '0, 0, 0, 0, 0, 0, "R7 R8 idle");
    step('0, '0, 0, 0, 0, 1, 0, "R7 no stale pend");
    // pseudo-random sweep over all input combinations
    lf = 16'hACE1;
    for (int c = 0; c < 6000; c++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step({lf[1] & lf[5], lf[0] & lf[4]}, lf[3:2], lf[6], lf[7],
           lf[12] & lf[13] & lf[14], lf[9], lf[10] | lf[11], "R2 R3 R5 R6 R7 R9 sweep");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule